// File: doc/BRIEF.md
# Switch MAC Address Lookup Table

This block holds a small table of MAC address entries for an Ethernet switch and decides, for each destination address presented on its lookup interface, which egress ports should carry the frame. Software fills the table through a 32-bit register port. Each entry is 68 bits wide, so it is reached indirectly: three data registers stage an entry, and a table-control register moves an entry between a table slot and those registers in either direction.

A lookup compares the requested address with every address-bearing entry at once. It answers one cycle later with a hit flag and a port mask. A unicast hit selects a single port. A multicast hit selects a stored port set. A miss floods to every port that is forwarding. Per-port state registers gate every answer, so a port that is not forwarding never appears in a mask. A control register enables the engine and can wipe the whole table. The wipe walks the table one slot per cycle, and lookups are held off while it runs.

Top module: `lkup_engine`

## Requirements
- R1: Data register 0x34 holds entry bits 67:64 in its low four bits and reads zero above them, 0x38 holds bits 63:32 and 0x3C holds bits 31:0. Writing an index with bit 31 set to 0x20 stores the three registers into that slot. Writing an index with bit 31 clear loads that slot into the three registers.
- R2: After reset the control register reads 0, every port state reads 0 (disabled), every slot loads as all zeros (free), `lk_req_ready` is 1 and `lk_resp_valid` is 0.
- R3: A request accepted on a clock edge (`lk_req_valid` and `lk_req_ready` both high) gives `lk_resp_valid` high for exactly the following cycle. No response appears without an accepted request.
- R4: An entry takes part in matching only when its kind field (bits 61:60) is 1 (address) or 3 (VLAN plus address) and its bits 47:0 equal the requested MAC. Kinds 0 (free) and 2 (VLAN) never match.
- R5: When several entries match, the one at the lowest index decides the result.
- R6: A unicast hit (entry bit 40 = 0) gives hit = 1 and a mask with only the bit of the port number in bits 67:66 set. The mask is empty when bit 65 (blocked) is set or the port number is not below the port count. Bit 64 (secure) does not change the result.
- R7: A multicast hit (entry bit 40 = 1) gives hit = 1 and a mask equal to entry bits 67:66 ANDed with the set of forwarding ports.
- R8: A miss gives hit = 0 and a mask of all ports whose state is 3.
- R9: No response mask ever includes a port whose state is 0, 1 or 2.
- R10: Control bit 31 enables the engine. While it is 0, every response has hit = 0 and an empty mask.
- R11: Writing control bit 30 as 1 frees every slot, one slot per cycle. Bit 30 reads 1 until the last slot is done and then reads 0, and `lk_req_ready` is 0 for that whole time.
- R12: Port p has a state register at 0x40 + 4p. Its two low bits (0 disabled, 1 blocked, 2 learning, 3 forwarding) are stored and read back, and the upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address (writes and combinational reads) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| lk_req_valid | input | 1 | Lookup request present |
| lk_req_ready | output | 1 | Lookup can be accepted (low during a table wipe) |
| lk_req_mac | input | 48 | Destination MAC, first transmitted byte in bits 47:40 |
| lk_resp_valid | output | 1 | Lookup answer present |
| lk_resp_hit | output | 1 | An address entry matched |
| lk_resp_mask | output | PORTS | Ports that should forward the frame |

## Verification
The same table is swept over all sixteen combinations of the two port states and all four stored multicast masks. It is probed with six destinations: one shadowed by free, VLAN-only and lower-priority entries, a multicast group, a plain unicast, a blocked unicast, a unicast naming a nonexistent port, and an unknown address. Together these separate a wrong priority, a leaky kind filter, missing state gating, a blocked flag that is ignored and a wrong flood set. Separate passes check the word split and its unused upper bits, the disabled engine, and the wipe, which is checked for its stall window and for the table left behind.

// File: rtl/lkup_pkg.sv
`timescale 1ns/1ps
package lkup_pkg;
    localparam logic [7:0] OFF_CTRL      = 8'h08;
    localparam logic [7:0] OFF_TBL_CTL   = 8'h20;
    localparam logic [7:0] OFF_WORD0     = 8'h34;
    localparam logic [7:0] OFF_WORD1     = 8'h38;
    localparam logic [7:0] OFF_WORD2     = 8'h3C;
    localparam logic [7:0] OFF_PORT_BASE = 8'h40;

    localparam int F_KIND_LO  = 60;
    localparam int F_GROUP    = 40;
    localparam int F_BLOCKED  = 65;
    localparam int F_PORT_LO  = 66;
    localparam int PNUM_W     = 2;

    typedef enum logic [1:0] {
        ENT_FREE      = 2'd0,
        ENT_ADDR      = 2'd1,
        ENT_VLAN      = 2'd2,
        ENT_VLAN_ADDR = 2'd3
    } ent_kind_e;

    typedef enum logic [1:0] {
        PST_OFF   = 2'd0,
        PST_BLOCK = 2'd1,
        PST_LEARN = 2'd2,
        PST_FWD   = 2'd3
    } port_state_e;
endpackage

// File: rtl/lkup_table.sv
`timescale 1ns/1ps
module lkup_table #(
    parameter int ENTRIES = 8,
    parameter int ENTRY_W = 68,
    parameter int IDX_W   = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [ENTRY_W-1:0]               wr_data,
    input  logic                             clr_start,
    output logic [ENTRIES-1:0][ENTRY_W-1:0]  tbl,
    output logic                             clr_busy
);
    typedef struct packed {
        logic [ENTRIES-1:0][ENTRY_W-1:0] ent;
        logic                            busy;
        logic [IDX_W-1:0]                cnt;
    } tbl_st_t;

    tbl_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.ent[wr_idx] = wr_data;
        end
        if (s_q.busy) begin
            s_d.ent[s_q.cnt] = '0;
            s_d.cnt          = s_q.cnt + 1'b1;
            if (s_q.cnt == IDX_W'(ENTRIES - 1)) begin
                s_d.busy = 1'b0;
            end
        end else if (clr_start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tbl      = s_q.ent;
    assign clr_busy = s_q.busy;
endmodule

// File: rtl/lkup_match.sv
`timescale 1ns/1ps
module lkup_match
    import lkup_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ENTRY_W = 68,
    parameter int PORTS   = 2
) (
    input  logic [ENTRIES-1:0][ENTRY_W-1:0] tbl,
    input  logic [47:0]                     mac,
    input  logic [PORTS-1:0]                fwd,
    output logic                            hit,
    output logic [PORTS-1:0]                mask
);
    logic [ENTRIES-1:0] cand;
    logic [ENTRY_W-1:0] sel;
    logic               sel_unused;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic [1:0] kind;
        assign kind    = tbl[i][F_KIND_LO +: 2];
        assign cand[i] = ((kind == ENT_ADDR) || (kind == ENT_VLAN_ADDR)) &&
                         (tbl[i][47:0] == mac);
    end

    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit = 1'b1;
                sel = tbl[i];
            end
        end
        if (!hit) begin
            mask = fwd;
        end else if (sel[F_GROUP]) begin
            mask = sel[F_PORT_LO +: PORTS] & fwd;
        end else if (sel[F_BLOCKED]) begin
            mask = '0;
        end else begin
            mask = '0;
            for (int p = 0; p < PORTS; p++) begin
                if (sel[F_PORT_LO +: PNUM_W] == PNUM_W'(p)) begin
                    mask[p] = 1'b1;
                end
            end
            mask = mask & fwd;
        end
    end

    assign sel_unused = ^sel;
endmodule

// File: rtl/lkup_engine.sv
`timescale 1ns/1ps
module lkup_engine
    import lkup_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PORTS   = 2,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lk_req_valid,
    output logic              lk_req_ready,
    input  logic [47:0]       lk_req_mac,
    output logic              lk_resp_valid,
    output logic              lk_resp_hit,
    output logic [PORTS-1:0]  lk_resp_mask
);
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int ENTRY_W = F_PORT_LO + ((PORTS > PNUM_W) ? PORTS : PNUM_W);

    typedef struct packed {
        logic                   en;
        logic                   vlan;
        logic [IDX_W-1:0]       idx;
        logic [2:0][31:0]       word;
        logic [PORTS-1:0][1:0]  pst;
        logic                   resp_valid;
        logic                   resp_hit;
        logic [PORTS-1:0]       resp_mask;
    } eng_st_t;

    eng_st_t s_d, s_q;

    logic [ENTRIES-1:0][ENTRY_W-1:0] tbl;
    logic                            clr_busy;
    logic                            tbl_we;
    logic [ENTRY_W-1:0]              tbl_wdata;
    logic                            clr_go;
    logic [PORTS-1:0]                fwd_vec;
    logic                            m_hit;
    logic [PORTS-1:0]                m_mask;
    logic [IDX_W-1:0]                wd_idx;
    logic                            wd_idx_ok;
    logic [95:0]                     ld_bits;
    logic                            en_q;

    assign wd_idx    = reg_wdata[IDX_W-1:0];
    assign wd_idx_ok = (reg_wdata[30:0] < 31'(ENTRIES));
    assign ld_bits   = 96'(tbl[wd_idx]);
    assign tbl_wdata = ENTRY_W'({s_q.word[0], s_q.word[1], s_q.word[2]});

    for (genvar p = 0; p < PORTS; p++) begin : g_fwd
        assign fwd_vec[p] = (s_q.pst[p] == PST_FWD);
    end

    lkup_table #(.ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_idx   (wd_idx),
        .wr_data  (tbl_wdata),
        .clr_start(clr_go),
        .tbl      (tbl),
        .clr_busy (clr_busy)
    );

    lkup_match #(.ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W), .PORTS(PORTS)) u_match (
        .tbl (tbl),
        .mac (lk_req_mac),
        .fwd (fwd_vec),
        .hit (m_hit),
        .mask(m_mask)
    );

    assign lk_req_ready = !clr_busy;

    always_comb begin
        s_d    = s_q;
        tbl_we = 1'b0;
        clr_go = 1'b0;

        s_d.resp_valid = lk_req_valid && lk_req_ready;
        s_d.resp_hit   = s_q.en && m_hit;
        s_d.resp_mask  = s_q.en ? m_mask : '0;

        if (reg_wr) begin
            if (reg_addr == ADDR_W'(OFF_CTRL)) begin
                s_d.en   = reg_wdata[31];
                s_d.vlan = reg_wdata[2];
                clr_go   = reg_wdata[30];
            end else if (reg_addr == ADDR_W'(OFF_TBL_CTL)) begin
                if (wd_idx_ok) begin
                    s_d.idx = wd_idx;
                    if (reg_wdata[31]) begin
                        tbl_we = 1'b1;
                    end else begin
                        s_d.word[0] = ld_bits[95:64];
                        s_d.word[1] = ld_bits[63:32];
                        s_d.word[2] = ld_bits[31:0];
                    end
                end
            end else if (reg_addr == ADDR_W'(OFF_WORD0)) begin
                s_d.word[0] = {{(96 - ENTRY_W){1'b0}}, reg_wdata[ENTRY_W-65:0]};
            end else if (reg_addr == ADDR_W'(OFF_WORD1)) begin
                s_d.word[1] = reg_wdata;
            end else if (reg_addr == ADDR_W'(OFF_WORD2)) begin
                s_d.word[2] = reg_wdata;
            end
            for (int p = 0; p < PORTS; p++) begin
                if (reg_addr == ADDR_W'(int'(OFF_PORT_BASE) + 4 * p)) begin
                    s_d.pst[p] = reg_wdata[1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFF_CTRL)) begin
            reg_rdata = {s_q.en, clr_busy, 27'b0, s_q.vlan, 2'b0};
        end else if (reg_addr == ADDR_W'(OFF_TBL_CTL)) begin
            reg_rdata = 32'(s_q.idx);
        end else if (reg_addr == ADDR_W'(OFF_WORD0)) begin
            reg_rdata = s_q.word[0];
        end else if (reg_addr == ADDR_W'(OFF_WORD1)) begin
            reg_rdata = s_q.word[1];
        end else if (reg_addr == ADDR_W'(OFF_WORD2)) begin
            reg_rdata = s_q.word[2];
        end
        for (int p = 0; p < PORTS; p++) begin
            if (reg_addr == ADDR_W'(int'(OFF_PORT_BASE) + 4 * p)) begin
                reg_rdata = {30'b0, s_q.pst[p]};
            end
        end
    end

    assign en_q          = s_q.en;
    assign lk_resp_valid = s_q.resp_valid;
    assign lk_resp_hit   = s_q.resp_hit;
    assign lk_resp_mask  = s_q.resp_mask;
endmodule

// File: rtl/lkup_chk.sv
`timescale 1ns/1ps
module lkup_chk
    import lkup_pkg::*;
#(
    parameter int PORTS  = 2,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              lk_req_valid,
    input logic              lk_req_ready,
    input logic              lk_resp_valid,
    input logic              lk_resp_hit,
    input logic [PORTS-1:0]  lk_resp_mask,
    input logic [PORTS-1:0]  fwd,
    input logic              en,
    input logic              clr_busy
);
    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req_valid && lk_req_ready) |=> lk_resp_valid); // R3

    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_req_valid && lk_req_ready) |=> !lk_resp_valid); // R3

    AST_MASK_WITHIN_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        lk_resp_valid |-> ((lk_resp_mask & ~$past(fwd)) == '0)); // R9

    AST_MISS_FLOODS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_resp_valid && !lk_resp_hit && $past(en)) |-> (lk_resp_mask == $past(fwd))); // R8

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_resp_valid && !$past(en)) |-> ((lk_resp_mask == '0) && !lk_resp_hit)); // R10

    AST_WIPE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == ADDR_W'(OFF_CTRL)) && reg_wdata[30] && !clr_busy)
        |=> !lk_req_ready); // R11
endmodule

bind lkup_engine lkup_chk #(.PORTS(PORTS), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .lk_req_valid (lk_req_valid),
    .lk_req_ready (lk_req_ready),
    .lk_resp_valid(lk_resp_valid),
    .lk_resp_hit  (lk_resp_hit),
    .lk_resp_mask (lk_resp_mask),
    .fwd          (fwd_vec),
    .en           (en_q),
    .clr_busy     (clr_busy)
);

// File: tb/sim_lkup_engine.sv
`timescale 1ns/1ps
module sim_lkup_engine;
    localparam int ENTRIES = 8;
    localparam int PORTS   = 2;

    localparam logic [47:0] MAC_A    = 48'h02_11_22_33_44_55;
    localparam logic [47:0] MAC_M    = 48'h01_00_5E_00_00_01;
    localparam logic [47:0] MAC_U2   = 48'h02_AA_00_00_00_02;
    localparam logic [47:0] MAC_UB   = 48'h02_BB_00_00_00_03;
    localparam logic [47:0] MAC_UX   = 48'h02_CC_00_00_00_04;
    localparam logic [47:0] MAC_MISS = 48'h02_DD_00_00_00_05;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [7:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              lk_req_valid = 1'b0;
    logic              lk_req_ready;
    logic [47:0]       lk_req_mac = '0;
    logic              lk_resp_valid;
    logic              lk_resp_hit;
    logic [PORTS-1:0]  lk_resp_mask;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    lkup_engine #(.ENTRIES(ENTRIES), .PORTS(PORTS), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_req_valid(lk_req_valid), .lk_req_ready(lk_req_ready),
        .lk_req_mac(lk_req_mac), .lk_resp_valid(lk_resp_valid),
        .lk_resp_hit(lk_resp_hit), .lk_resp_mask(lk_resp_mask)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [67:0] mk(input logic [1:0] kind, input logic [47:0] mac,
                                       input logic [3:0] hi4, input logic [1:0] t2);
        return {hi4, t2, kind, 12'h000, mac};
    endfunction

    task automatic put_entry(input int idx, input logic [67:0] e);
        reg_write(8'h34, {28'h0, e[67:64]});
        reg_write(8'h38, e[63:32]);
        reg_write(8'h3C, e[31:0]);
        reg_write(8'h20, 32'h8000_0000 | idx);
    endtask

    // returns {hit, mask}; also checks R3 valid-in-next-cycle
    task automatic lookup(input logic [47:0] mac, output logic [2:0] res);
        @(negedge clk);
        while (!lk_req_ready) @(negedge clk);
        lk_req_valid = 1'b1; lk_req_mac = mac;
        @(negedge clk);
        lk_req_valid = 1'b0;
        chk("R3 resp valid", 32'(lk_resp_valid), 32'd1);
        res = {lk_resp_hit, lk_resp_mask};
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        logic [2:0]  res;
        logic [1:0]  fwd;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        reg_read(8'h08, rd); chk("R2 ctrl", rd, 32'h0);
        reg_read(8'h40, rd); chk("R2 port0", rd, 32'h0);
        reg_read(8'h44, rd); chk("R2 port1", rd, 32'h0);
        chk("R2 ready", 32'(lk_req_ready), 32'd1);
        chk("R2 resp idle", 32'(lk_resp_valid), 32'd0);
        reg_write(8'h20, 32'd6);
        reg_read(8'h38, rd); chk("R2 slot free", rd, 32'h0);

        // R12 port register width
        reg_write(8'h44, 32'hFFFF_FFFE);
        reg_read(8'h44, rd); chk("R12 port1 rb", rd, 32'h2);

        // R10 enable readback
        reg_write(8'h08, 32'h8000_0000);
        reg_read(8'h08, rd); chk("R10 ctrl rb", rd, 32'h8000_0000);

        // R1 word order and width
        reg_write(8'h34, 32'hFFFF_FFFF);
        reg_write(8'h38, 32'h1234_5678);
        reg_write(8'h3C, 32'h9ABC_DEF0);
        reg_write(8'h20, 32'h8000_0005);
        reg_write(8'h34, 32'h0); reg_write(8'h38, 32'h0); reg_write(8'h3C, 32'h0);
        reg_write(8'h20, 32'h0000_0005);
        reg_read(8'h34, rd); chk("R1 word0", rd, 32'h0000_000F);
        reg_read(8'h38, rd); chk("R1 word1", rd, 32'h1234_5678);
        reg_read(8'h3C, rd); chk("R1 word2", rd, 32'h9ABC_DEF0);
        reg_read(8'h20, rd); chk("R1 index", rd, 32'h5);

        // R11 wipe with stall window
        reg_write(8'h08, 32'hC000_0000);
        reg_read(8'h08, rd); chk("R11 busy bit", rd, 32'hC000_0000);
        chk("R11 stalled", 32'(lk_req_ready), 32'd0);
        repeat (ENTRIES + 2) @(negedge clk);
        reg_read(8'h08, rd); chk("R11 done bit", rd, 32'h8000_0000);
        chk("R11 ready again", 32'(lk_req_ready), 32'd1);
        reg_write(8'h20, 32'd5);
        reg_read(8'h34, rd); chk("R11 wiped w0", rd, 32'h0);
        reg_read(8'h38, rd); chk("R11 wiped w1", rd, 32'h0);

        // table for the sweep
        put_entry(0, mk(2'd2, MAC_A, 4'b0100, 2'd0)); // VLAN kind, no match (R4)
        put_entry(1, mk(2'd0, MAC_A, 4'b0000, 2'd0)); // free, no match (R4)
        put_entry(2, mk(2'd1, MAC_A, 4'b0100, 2'd0)); // port 1, first real match
        put_entry(3, mk(2'd3, MAC_A, 4'b0000, 2'd0)); // port 0, shadowed (R5)
        put_entry(5, mk(2'd1, MAC_U2, 4'b0001, 2'd3)); // port 0, secure
        put_entry(6, mk(2'd3, MAC_UB, 4'b0110, 2'd0)); // port 1, blocked
        put_entry(7, mk(2'd3, MAC_UX, 4'b1100, 2'd0)); // port 3, out of range

        for (int m = 0; m < 4; m++) begin
            put_entry(4, mk(2'd1, MAC_M, {m[1:0], 2'b00}, 2'd3));
            for (int st = 0; st < 16; st++) begin
                reg_write(8'h40, 32'(st[1:0]));
                reg_write(8'h44, 32'(st[3:2]));
                reg_read(8'h40, rd); chk("R12 port0 rb", rd, 32'(st[1:0]));
                fwd = {st[3:2] == 2'd3, st[1:0] == 2'd3};

                lookup(MAC_A, res);
                chk("R5 R4 priority", 32'(res), 32'({1'b1, 2'b10 & fwd}));
                lookup(MAC_M, res);
                chk("R7 mcast", 32'(res), 32'({1'b1, m[1:0] & fwd}));
                chk("R9 gating", 32'(res[1:0] & ~fwd), 32'd0);
                lookup(MAC_U2, res);
                chk("R6 ucast secure", 32'(res), 32'({1'b1, 2'b01 & fwd}));
                lookup(MAC_UB, res);
                chk("R6 blocked", 32'(res), 32'b100);
                lookup(MAC_UX, res);
                chk("R6 bad port", 32'(res), 32'b100);
                lookup(MAC_MISS, res);
                chk("R8 flood", 32'(res), 32'({1'b0, fwd}));
            end
        end

        // R3 single response
        @(negedge clk);
        chk("R3 one pulse", 32'(lk_resp_valid), 32'd0);

        // R10 disabled engine
        reg_write(8'h40, 32'd3); reg_write(8'h44, 32'd3);
        reg_write(8'h08, 32'h0);
        lookup(MAC_A, res);    chk("R10 off hit", 32'(res), 32'd0);
        lookup(MAC_MISS, res); chk("R10 off miss", 32'(res), 32'd0);

        // R11 lookup after wipe misses
        reg_write(8'h08, 32'hC000_0000);
        lookup(MAC_A, res);    chk("R11 after wipe", 32'(res), 32'b011);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule